// File: doc/BRIEF.md
# Multi-Width Sequential Integer Divider

This block divides a double-width dividend by a single-width divisor. The operand width can be 8, 16, 32 or 64 bits, and the division can be unsigned or signed. The dividend comes from a pair of registers: an accumulator and a data register. For the byte size, the whole 16-bit dividend is the low 16 bits of the accumulator. For the wider sizes, the data register holds the high half and the accumulator holds the low half. The block returns a quotient and a remainder. A quotient is written to the accumulator side of the result and a remainder to the data side; for the byte size these are the low byte and the byte above it. A divisor of zero, or a quotient that does not fit the operand width, raises a divide-error fault instead of a result.

A single start pulse launches a division. A preparation stage turns both operands into magnitudes. An unsigned shift-subtract core then makes one quotient bit per cycle. A fix-up stage restores the signs and checks the signed range. If the high half of the dividend magnitude already reaches the divisor, the fault is reported at once and the core does not run. The surrounding pipeline consumes the results. Writeback to registers and delivery of the exception are left to that pipeline.

Top module: `div_unit`

## Requirements
- R1: With size code 0 (8-bit), the dividend is `acc_i[15:0]`. For every size, an unsigned success returns quotient and remainder in the low n bits of `quo_o` and `rem_o`, with all bits above n zero.
- R2: With size code 1, 2 or 3 (16, 32 or 64 bits), the dividend is `{dat_i[n-1:0], acc_i[n-1:0]}` and the divisor is `dvs_i[n-1:0]`. Input bits above those fields have no effect.
- R3: A divisor whose low n bits are all zero raises `fault_o` in the done cycle, and `quo_o` and `rem_o` keep their previous values.
- R4: An unsigned division whose dividend high half is greater than or equal to the divisor faults without iterating, and the outputs keep their previous values.
- R5: A signed division (`sgn_i`=1) divides the magnitudes. The quotient is negated when the operand signs differ. The remainder takes the sign of the dividend. Both results are given in n-bit two's complement.
- R6: A signed quotient that is negative may have a magnitude up to 2^(n-1). A signed quotient that is non-negative must be below 2^(n-1). Otherwise the block faults.
- R7: `done_o` is high for exactly one cycle. Take the clock edge that samples `start_i` as edge 0. A fault detected at setup (zero divisor, or high half too large) gives done after edge 1. Any other division gives done after edge n+1.
- R8: A `start_i` pulse that arrives while a division is in progress is ignored. The result belongs to the operands that were accepted.
- R9: `fault_o` is high only together with `done_o`. `busy_o` is high from the cycle after an accepted start until the done cycle, and is low in the done cycle.
- R10: After reset, `done_o`, `fault_o` and `busy_o` are low, and `quo_o` and `rem_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a division when the block is idle |
| size_i | input | 2 | Operand width code: 0=8, 1=16, 2=32, 3=64 bits |
| sgn_i | input | 1 | 1 selects signed division |
| acc_i | input | 64 | Accumulator: low half of the dividend, or all of it for the byte size |
| dat_i | input | 64 | Data register: high half of the dividend for sizes 16 and wider |
| dvs_i | input | 64 | Divisor; its low n bits are used |
| quo_o | output | 64 | Quotient, zero-extended from n bits |
| rem_o | output | 64 | Remainder, zero-extended from n bits |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Divide-error fault, valid with done_o |
| busy_o | output | 1 | A division is in progress |

## Verification
Results and the fault flag are due in the cycle after clock edge 1 when a fault is detected at setup. Otherwise they are due after edge n+1, counted from the edge that samples start: 10, 18, 34 or 66 observed cycles for the four sizes. The bench drives and samples on the falling clock edge. It counts falling edges from the start pulse until done and compares that count with the latency predicted for each vector's size and fault class. It checks the outputs in that same cycle and confirms that done is low one cycle later. On fault vectors, the outputs are compared with the values captured before the start. This shows that nothing was written.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int DW = 64;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_D = 2'd2,
    SZ_Q = 2'd3
  } dsize_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } dstate_e;

  function automatic int unsigned sz_bits(dsize_e s);
    return 32'd8 << s;
  endfunction
endpackage

// File: rtl/div_prep.sv
module div_prep
  import div_pkg::*;
#(
  parameter int W = DW
) (
  input  dsize_e         size_i,
  input  logic           sgn_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   dat_i,
  input  logic [W-1:0]   dvs_i,
  output logic [W-1:0]   hi_o,
  output logic [W-1:0]   lo_o,
  output logic [W-1:0]   dmag_o,
  output logic           neg_q_o,
  output logic           neg_r_o,
  output logic           zero_o,
  output logic           ovf_o
);
  localparam int W2 = 2 * W;
  localparam logic [W-1:0]  ONE1 = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W2-1:0] ONE2 = {{(W2-1){1'b0}}, 1'b1};

  int unsigned       n;
  logic [W-1:0]      m1, dvs_m, lo;
  logic [W2-1:0]     m2, dvd, dvd_mag;
  logic              sa, sb;

  always_comb begin
    n     = sz_bits(size_i);
    m1    = (ONE1 << n) - ONE1;
    m2    = (ONE2 << (2 * n)) - ONE2;
    dvs_m = dvs_i & m1;
    if (size_i == SZ_B) dvd = {{W{1'b0}}, acc_i} & m2;
    else dvd = ({{W{1'b0}}, dat_i & m1} << n) | {{W{1'b0}}, acc_i & m1};
    // top bit of each field via mask edge, avoids a variable index
    sa      = sgn_i & (|(dvd & (m2 & ~(m2 >> 1))));
    sb      = sgn_i & (|(dvs_m & (m1 & ~(m1 >> 1))));
    dvd_mag = sa ? ((~dvd + ONE2) & m2) : dvd;
    dmag_o  = sb ? ((~dvs_m + ONE1) & m1) : dvs_m;
    hi_o    = W'(dvd_mag >> n);
    lo      = dvd_mag[W-1:0] & m1;
    lo_o    = lo << (W - n);
    neg_q_o = sa ^ sb;
    neg_r_o = sa;
    zero_o  = (dvs_m == '0);
    ovf_o   = (hi_o >= dmag_o);
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 64,
  localparam int CW = $clog2(W + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [W-1:0]   hi_i,
  input  logic [W-1:0]   lo_i,
  input  logic [W-1:0]   dvs_i,
  input  logic [CW-1:0]  n_i,
  output logic [W-1:0]   q_o,
  output logic [W-1:0]   r_o,
  output logic           last_o
);
  logic [W-1:0]  r_q, l_q, d_q, q_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    trial, diff;
  logic          take;

  always_comb begin
    trial = {r_q, l_q[W-1]};
    diff  = trial - {1'b0, d_q};
    take  = (trial >= {1'b0, d_q});  // bit W set covers the shifted-out case
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q   <= '0;
      l_q   <= '0;
      d_q   <= '0;
      q_q   <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      r_q   <= hi_i;
      l_q   <= lo_i;
      d_q   <= dvs_i;
      q_q   <= '0;
      cnt_q <= n_i;
    end else if (cnt_q != '0) begin
      r_q   <= take ? diff[W-1:0] : trial[W-1:0];
      l_q   <= l_q << 1;
      q_q   <= {q_q[W-2:0], take};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign q_o    = q_q;
  assign r_o    = r_q;
  assign last_o = (cnt_q == {{(CW-1){1'b0}}, 1'b1});

  // partial remainder stays below divisor while iterating (R4 precondition)
  p_rem_below_div_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (r_q < d_q));
endmodule

// File: rtl/div_fix.sv
module div_fix
  import div_pkg::*;
#(
  parameter int W = DW
) (
  input  dsize_e         size_i,
  input  logic           sgn_i,
  input  logic           neg_q_i,
  input  logic           neg_r_i,
  input  logic [W-1:0]   q_i,
  input  logic [W-1:0]   r_i,
  output logic [W-1:0]   quo_o,
  output logic [W-1:0]   rem_o,
  output logic           rng_flt_o
);
  localparam logic [W-1:0] ONE1 = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] m1, lim;

  always_comb begin
    m1        = (ONE1 << sz_bits(size_i)) - ONE1;
    lim       = m1 & ~(m1 >> 1);
    rng_flt_o = sgn_i & (neg_q_i ? (q_i > lim) : (q_i >= lim));
    quo_o     = (neg_q_i ? (~q_i + ONE1) : q_i) & m1;
    rem_o     = (neg_r_i ? (~r_i + ONE1) : r_i) & m1;
  end
endmodule

// File: rtl/div_unit.sv
module div_unit
  import div_pkg::*;
#(
  parameter int W = DW,
  localparam int CW = $clog2(W + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [1:0]     size_i,
  input  logic           sgn_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   dat_i,
  input  logic [W-1:0]   dvs_i,
  output logic [W-1:0]   quo_o,
  output logic [W-1:0]   rem_o,
  output logic           done_o,
  output logic           fault_o,
  output logic           busy_o
);
  localparam logic [W-1:0] ONE1 = {{(W-1){1'b0}}, 1'b1};

  dstate_e      st_q;
  dsize_e       sz_q, sz_in;
  logic         sgn_q, nq_q, nr_q, eflt_q;
  logic [W-1:0] quo_q, rem_q;
  logic         done_q, flt_q;

  logic [W-1:0] p_hi, p_lo, p_dmag;
  logic         p_nq, p_nr, p_zero, p_ovf;
  logic [W-1:0] c_q, c_r;
  logic         c_last;
  logic [W-1:0] f_quo, f_rem;
  logic         f_rng;
  logic         accept, early;

  assign sz_in  = dsize_e'(size_i);
  assign accept = start_i && (st_q == ST_IDLE);
  assign early  = p_zero || p_ovf;

  div_prep #(.W(W)) u_prep (
    .size_i (sz_in),
    .sgn_i  (sgn_i),
    .acc_i  (acc_i),
    .dat_i  (dat_i),
    .dvs_i  (dvs_i),
    .hi_o   (p_hi),
    .lo_o   (p_lo),
    .dmag_o (p_dmag),
    .neg_q_o(p_nq),
    .neg_r_o(p_nr),
    .zero_o (p_zero),
    .ovf_o  (p_ovf)
  );

  div_core #(.W(W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept && !early),
    .hi_i   (p_hi),
    .lo_i   (p_lo),
    .dvs_i  (p_dmag),
    .n_i    (CW'(sz_bits(sz_in))),
    .q_o    (c_q),
    .r_o    (c_r),
    .last_o (c_last)
  );

  div_fix #(.W(W)) u_fix (
    .size_i   (sz_q),
    .sgn_i    (sgn_q),
    .neg_q_i  (nq_q),
    .neg_r_i  (nr_q),
    .q_i      (c_q),
    .r_i      (c_r),
    .quo_o    (f_quo),
    .rem_o    (f_rem),
    .rng_flt_o(f_rng)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sz_q   <= SZ_B;
      sgn_q  <= 1'b0;
      nq_q   <= 1'b0;
      nr_q   <= 1'b0;
      eflt_q <= 1'b0;
      quo_q  <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      flt_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          sz_q   <= sz_in;
          sgn_q  <= sgn_i;
          nq_q   <= p_nq;
          nr_q   <= p_nr;
          eflt_q <= early;
          st_q   <= early ? ST_FIX : ST_RUN;
        end
        ST_RUN: if (c_last) st_q <= ST_FIX;
        ST_FIX: begin
          done_q <= 1'b1;
          if (eflt_q || f_rng) begin
            flt_q <= 1'b1;
          end else begin
            quo_q <= f_quo;
            rem_q <= f_rem;
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign quo_o   = quo_q;
  assign rem_o   = rem_q;
  assign done_o  = done_q;
  assign fault_o = flt_q;
  assign busy_o  = (st_q != ST_IDLE);

  logic [W-1:0] a_m, a_top;
  assign a_m   = (ONE1 << sz_bits(sz_q)) - ONE1;
  assign a_top = a_m & ~(a_m >> 1);

  p_done_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_fault_in_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);
  p_hold_on_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> ($stable(quo_o) && $stable(rem_o)));
  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |=> ($stable(sz_q) && $stable(sgn_q)));
  p_upper_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> (((quo_o | rem_o) & ~a_m) == '0));
  p_pos_quot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o && sgn_q && !nq_q) |-> ((quo_o & a_top) == '0));
  p_busy_off_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/sim_div_unit.sv
module sim_div_unit;
  localparam int CLK_P = 10;
  localparam int NV    = 18;

  typedef struct packed {
    logic [1:0]  sz;
    logic        sg;
    logic [63:0] acc;
    logic [63:0] dat;
    logic [63:0] dvs;
    logic [1:0]  fk;   // 0 ok, 1 setup fault, 2 range fault
    logic [3:0]  rq;
    logic [63:0] q;
    logic [63:0] r;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_0064, 64'h0, 64'hAB07, 2'd0, 4'd1, 64'h0E, 64'h02},
    '{2'd0, 1'b0, 64'h0100, 64'h0, 64'h1, 2'd1, 4'd4, 64'h0, 64'h0},
    '{2'd1, 1'b0, 64'h1234_0000_0000_0000, 64'hDEAD_0000_0000_0001, 64'h3, 2'd0, 4'd2, 64'h5555, 64'h1},
    '{2'd2, 1'b0, 64'hFFFF_FFFF, 64'h0, 64'h10, 2'd0, 4'd2, 64'h0FFF_FFFF, 64'hF},
    '{2'd3, 1'b0, 64'h0, 64'h1, 64'h2, 2'd0, 4'd2, 64'h8000_0000_0000_0000, 64'h0},
    '{2'd3, 1'b0, 64'h7, 64'h5, 64'h5, 2'd1, 4'd4, 64'h0, 64'h0},
    '{2'd0, 1'b1, 64'hFF9C, 64'h0, 64'h07, 2'd0, 4'd5, 64'hF2, 64'hFE},
    '{2'd0, 1'b1, 64'hFF80, 64'h0, 64'h01, 2'd0, 4'd6, 64'h80, 64'h0},
    '{2'd0, 1'b1, 64'h0080, 64'h0, 64'h01, 2'd2, 4'd6, 64'h0, 64'h0},
    '{2'd0, 1'b1, 64'h0080, 64'h0, 64'hFF, 2'd0, 4'd6, 64'h80, 64'h0},
    '{2'd1, 1'b1, 64'h8000, 64'hFFFF, 64'hFFFF, 2'd2, 4'd6, 64'h0, 64'h0},
    '{2'd1, 1'b1, 64'h0064, 64'h0, 64'hFFF9, 2'd0, 4'd5, 64'hFFF2, 64'h2},
    '{2'd2, 1'b1, 64'hFFFF_FFF9, 64'hFFFF_FFFF, 64'h2, 2'd0, 4'd5, 64'hFFFF_FFFD, 64'hFFFF_FFFF},
    '{2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FF9C, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF6,
      2'd0, 4'd5, 64'hA, 64'h0},
    '{2'd3, 1'b0, 64'h0, 64'h3, 64'h1_0000_0000, 2'd0, 4'd2, 64'h3_0000_0000, 64'h0},
    '{2'd2, 1'b0, 64'h5, 64'h0, 64'hFFFF_FFFF_0000_0000, 2'd1, 4'd3, 64'h0, 64'h0},
    '{2'd1, 1'b0, 64'h5678, 64'h1234, 64'hABCD, 2'd0, 4'd1, 64'h1B20, 64'h3DD8},
    '{2'd0, 1'b1, 64'h0050, 64'h0, 64'hFF00, 2'd1, 4'd3, 64'h0, 64'h0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic        sgn_i = 1'b0;
  logic [63:0] acc_i = '0, dat_i = '0, dvs_i = '0;
  logic [63:0] quo_o, rem_o;
  logic        done_o, fault_o, busy_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P / 2) clk = ~clk;

  div_unit u0 (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .size_i (size_i),
    .sgn_i  (sgn_i),
    .acc_i  (acc_i),
    .dat_i  (dat_i),
    .dvs_i  (dvs_i),
    .quo_o  (quo_o),
    .rem_o  (rem_o),
    .done_o (done_o),
    .fault_o(fault_o),
    .busy_o (busy_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag(input logic [3:0] rq);
    case (rq)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic int lat(input vec_t v);
    return (v.fk == 2'd1) ? 2 : ((8 << v.sz) + 2);
  endfunction

  task automatic drive(input vec_t v);
    size_i = v.sz;
    sgn_i  = v.sg;
    acc_i  = v.acc;
    dat_i  = v.dat;
    dvs_i  = v.dvs;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    logic [63:0] q0, r0;
    int cyc;
    string t;
    t = tag(v.rq);
    @(negedge clk);
    q0 = quo_o;
    r0 = rem_o;
    drive(v);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    chk(busy_o === 1'b1, "R9", $sformatf("v%0d busy after start", idx), 64'(busy_o), 64'h1);
    while (done_o !== 1'b1 && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    // R7: latency from start edge
    chk(cyc == lat(v), "R7", $sformatf("v%0d latency", idx), 64'(cyc), 64'(lat(v)));
    chk(fault_o === (v.fk != 2'd0), t, $sformatf("v%0d fault", idx), 64'(fault_o),
        64'(v.fk != 2'd0));
    if (v.fk == 2'd0) begin
      chk(quo_o === v.q, t, $sformatf("v%0d quotient", idx), quo_o, v.q);
      chk(rem_o === v.r, t, $sformatf("v%0d remainder", idx), rem_o, v.r);
    end else begin
      chk(quo_o === q0, t, $sformatf("v%0d quotient held", idx), quo_o, q0);
      chk(rem_o === r0, t, $sformatf("v%0d remainder held", idx), rem_o, r0);
    end
    @(negedge clk);
    chk(done_o === 1'b0, "R7", $sformatf("v%0d done single cycle", idx), 64'(done_o), 64'h0);
    chk(fault_o === 1'b0, "R9", $sformatf("v%0d fault outside done", idx), 64'(fault_o), 64'h0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R7 watchdog expired actual=%h expected=%h", 64'h1, 64'h0);
    finish_run();
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(done_o === 1'b0, "R10", "reset done", 64'(done_o), 64'h0);
    chk(fault_o === 1'b0, "R10", "reset fault", 64'(fault_o), 64'h0);
    chk(busy_o === 1'b0, "R10", "reset busy", 64'(busy_o), 64'h0);
    chk(quo_o === 64'h0, "R10", "reset quotient", quo_o, 64'h0);
    chk(rem_o === 64'h0, "R10", "reset remainder", rem_o, 64'h0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R8: start while busy is ignored (64-bit op, second start mid-run)
    @(negedge clk);
    drive(VEC[4]);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    repeat (9) begin
      @(negedge clk);
      cyc++;
    end
    drive(VEC[0]);
    start_i = 1'b1;
    @(negedge clk);
    cyc++;
    start_i = 1'b0;
    drive(VEC[4]);
    while (done_o !== 1'b1 && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 66, "R8", "latency with ignored start", 64'(cyc), 64'd66);
    chk(quo_o === 64'h8000_0000_0000_0000, "R8", "quotient of first op", quo_o,
        64'h8000_0000_0000_0000);
    chk(rem_o === 64'h0, "R8", "remainder of first op", rem_o, 64'h0);
    chk(fault_o === 1'b0, "R8", "no fault", 64'(fault_o), 64'h0);
    @(negedge clk);
    chk(busy_o === 1'b0, "R8", "idle after done, second start dropped", 64'(busy_o), 64'h0);

    finish_run();
  end
endmodule